// File: doc/BRIEF.md
# Latched Status and Interrupt-Cause Register Pair

This block holds the interrupt causes and the error and count status of a bus controller. Other logic reports events as one-cycle pulses. Each pulse sets a bit that stays set. Any cause pulse also sets an interrupt-pending flag. That flag drives the interrupt output when interrupts are enabled. The three bus phase lines are not stored: they appear live in the low bits of the status word.

Software reads two registers through a combinational read port. A status read returns the pending flag, the latched status bits and the live phase, and it changes nothing. An interrupt read returns the latched causes. At the same clock edge it clears the causes, the latched status bits and the pending flag. A cause or status pulse that arrives in the cycle of that read is kept, so the next interrupt read reports it. A software reset pulse clears everything, and an asynchronous hardware reset does the same.

Top module: `cause_status_regs`

## Requirements
- R1: While the hardware reset is asserted, and right after it is released, the interrupt read returns 0x00, status bits 7..3 read 0 and intOut is 0.
- R2: A pulse on causePulse[i] sets interrupt-register bit i from the next cycle. Bit 7 is bus reset seen, 6 illegal command, 5 disconnect or timeout, 4 service request, 3 function complete, 2 reselected, 1 selected with attention, 0 selected. The bit stays set until it is cleared.
- R3: A pulse on statPulse sets a status bit from the next cycle and holds it. statPulse[3] sets status bit 6 (gross error), [2] sets bit 5 (parity error), [1] sets bit 4 (terminal count) and [0] sets bit 3 (valid group code).
- R4: Status bits 2..0 equal phaseLines (MSG, C/D, I/O) in the same cycle, with no latching. The legal codes are 0 data out, 1 data in, 2 command, 3 status, 6 message out and 7 message in. Codes 4 and 5 never occur.
- R5: Status bit 7 (pending) sets in the cycle after any cause pulse, whether or not intEnable is high.
- R6: intOut is high exactly when the pending bit is set and intEnable is high.
- R7: An interrupt read (rdIntr) returns the latched causes in the same cycle. From the next cycle it clears the causes, status bits 7..3 and intOut.
- R8: A status read (rdStatus) clears nothing.
- R9: A cause or status pulse in the same cycle as an interrupt read is latched after the clear and is reported by the next read.
- R10: A software reset pulse clears all latched bits from the next cycle. Pulses in the same cycle are discarded.
- R11: rdData is 0x00 when no read strobe is high. When both strobes are high, the interrupt read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| swReset | input | 1 | Software reset pulse |
| causePulse | input | 8 | Interrupt cause event pulses |
| statPulse | input | 4 | Error and count status event pulses |
| phaseLines | input | 3 | Live bus phase lines MSG, C/D, I/O |
| rdStatus | input | 1 | Status register read strobe |
| rdIntr | input | 1 | Interrupt register read strobe (clears) |
| intEnable | input | 1 | Interrupt output enable |
| rdData | output | 8 | Read data |
| intOut | output | 1 | Interrupt request |

## Verification
Read data and the phase bits are combinational, so they are due in the cycle the strobe is high. Every latch, set or clear is due one clock edge after its pulse or read. intOut follows the pending flag one edge after a cause pulse, and it follows intEnable at once. The bench drives inputs on the falling edge and compares rdData and intOut one nanosecond later against a model that holds the state from before the next rising edge. It then advances the model at that edge, so each stimulus is judged in the cycle its result is due.

// File: rtl/cause_status_pkg.sv
package cause_status_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CAUSE  = 2'd2
  } readSel_e;

  typedef struct packed {
    logic     wipe;     // discard all latched state and same-cycle pulses
    logic     restart;  // replace latched state with same-cycle pulses
    readSel_e sel;      // read mux selection
  } ctrlStrobe_t;

endpackage

// File: rtl/cause_status_ctrl.sv
module cause_status_ctrl
  import cause_status_pkg::*;
(
  input  logic        swReset,
  input  logic        rdStatus,
  input  logic        rdIntr,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.wipe    = swReset;
    strobe.restart = rdIntr && !swReset;
    if (rdIntr)        strobe.sel = SEL_CAUSE;
    else if (rdStatus) strobe.sel = SEL_STATUS;
    else               strobe.sel = SEL_NONE;
  end

endmodule

// File: rtl/cause_status_dp.sv
module cause_status_dp
  import cause_status_pkg::*;
#(
  parameter int CAUSE_W = 8,
  parameter int STAT_W  = 4,
  parameter int PHASE_W = 3,
  localparam int WORD_W = 1 + STAT_W + PHASE_W,
  localparam int DATA_W = (CAUSE_W > WORD_W) ? CAUSE_W : WORD_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [CAUSE_W-1:0] causePulse,
  input  logic [STAT_W-1:0]  statPulse,
  input  logic [PHASE_W-1:0] phaseLines,
  output logic [CAUSE_W-1:0] causeLatched,
  output logic [STAT_W-1:0]  statLatched,
  output logic               pendLatched,
  output logic [DATA_W-1:0]  rdData
);

  // Per-bit sticky cells for the cause bits
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               causeLatched[i] <= 1'b0;
      else if (strobe.wipe)    causeLatched[i] <= 1'b0;
      else if (strobe.restart) causeLatched[i] <= causePulse[i];
      else if (causePulse[i])  causeLatched[i] <= 1'b1;
    end
  end

  // Per-bit sticky cells for the status bits
  for (genvar j = 0; j < STAT_W; j++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               statLatched[j] <= 1'b0;
      else if (strobe.wipe)    statLatched[j] <= 1'b0;
      else if (strobe.restart) statLatched[j] <= statPulse[j];
      else if (statPulse[j])   statLatched[j] <= 1'b1;
    end
  end

  logic anyCause;
  assign anyCause = |causePulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pendLatched <= 1'b0;
    else if (strobe.wipe)    pendLatched <= 1'b0;
    else if (strobe.restart) pendLatched <= anyCause;
    else if (anyCause)       pendLatched <= 1'b1;
  end

  logic [WORD_W-1:0] statusWord;
  assign statusWord = {pendLatched, statLatched, phaseLines};

  always_comb begin
    rdData = '0;
    case (strobe.sel)
      SEL_CAUSE:  rdData[CAUSE_W-1:0] = causeLatched;
      SEL_STATUS: rdData[WORD_W-1:0]  = statusWord;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/cause_status_regs.sv
module cause_status_regs
  import cause_status_pkg::*;
#(
  parameter int CAUSE_W = 8,
  parameter int STAT_W  = 4,
  parameter int PHASE_W = 3,
  localparam int WORD_W = 1 + STAT_W + PHASE_W,
  localparam int DATA_W = (CAUSE_W > WORD_W) ? CAUSE_W : WORD_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               swReset,
  input  logic [CAUSE_W-1:0] causePulse,
  input  logic [STAT_W-1:0]  statPulse,
  input  logic [PHASE_W-1:0] phaseLines,
  input  logic               rdStatus,
  input  logic               rdIntr,
  input  logic               intEnable,
  output logic [DATA_W-1:0]  rdData,
  output logic               intOut
);

  ctrlStrobe_t        strobe;
  logic [CAUSE_W-1:0] causeLatched;
  logic [STAT_W-1:0]  statLatched;
  logic               pendLatched;

  cause_status_ctrl u_ctrl (
    .swReset  (swReset),
    .rdStatus (rdStatus),
    .rdIntr   (rdIntr),
    .strobe   (strobe)
  );

  cause_status_dp #(
    .CAUSE_W (CAUSE_W),
    .STAT_W  (STAT_W),
    .PHASE_W (PHASE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .causePulse   (causePulse),
    .statPulse    (statPulse),
    .phaseLines   (phaseLines),
    .causeLatched (causeLatched),
    .statLatched  (statLatched),
    .pendLatched  (pendLatched),
    .rdData       (rdData)
  );

  assign intOut = pendLatched & intEnable;

endmodule

// File: rtl/cause_status_chk.sv
module cause_status_chk #(
  parameter int CAUSE_W = 8,
  parameter int STAT_W  = 4,
  parameter int PHASE_W = 3,
  parameter int DATA_W  = 8
)(
  input logic               clk,
  input logic               rstN,
  input logic               swReset,
  input logic [CAUSE_W-1:0] causePulse,
  input logic [STAT_W-1:0]  statPulse,
  input logic [PHASE_W-1:0] phaseLines,
  input logic               rdStatus,
  input logic               rdIntr,
  input logic               intEnable,
  input logic [DATA_W-1:0]  rdData,
  input logic               intOut,
  input logic [CAUSE_W-1:0] causeLatched,
  input logic [STAT_W-1:0]  statLatched,
  input logic               pendLatched
);

  assert_cause_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && causePulse != '0) |=> ((causeLatched & $past(causePulse)) == $past(causePulse)));

  assert_cause_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && !rdIntr) |=> ((causeLatched & $past(causeLatched)) == $past(causeLatched)));

  assert_stat_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && !rdIntr) |=> ((statLatched & $past(statLatched)) == $past(statLatched)));

  assert_phase_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !rdIntr) |-> (rdData[PHASE_W-1:0] == phaseLines));

  assert_pend_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && causePulse != '0) |=> pendLatched);

  assert_int_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !intOut);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && causePulse == '0 && statPulse == '0) |=> (causeLatched == '0 && statLatched == '0 && !intOut));

  assert_status_read_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !rdIntr && !swReset) |=> (causeLatched == $past(causeLatched) || (causeLatched & $past(causeLatched)) == $past(causeLatched)));

  assert_same_cycle_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && !swReset) |=> (causeLatched == $past(causePulse) && statLatched == $past(statPulse)));

  assert_sw_wipe_R10: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (causeLatched == '0 && statLatched == '0 && !pendLatched));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdIntr && !rdStatus) |-> (rdData == '0));

endmodule

bind cause_status_regs cause_status_chk #(
  .CAUSE_W (CAUSE_W),
  .STAT_W  (STAT_W),
  .PHASE_W (PHASE_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .swReset      (swReset),
  .causePulse   (causePulse),
  .statPulse    (statPulse),
  .phaseLines   (phaseLines),
  .rdStatus     (rdStatus),
  .rdIntr       (rdIntr),
  .intEnable    (intEnable),
  .rdData       (rdData),
  .intOut       (intOut),
  .causeLatched (causeLatched),
  .statLatched  (statLatched),
  .pendLatched  (pendLatched)
);

// File: tb/test_cause_status_regs.sv
`timescale 1ns/1ps
module test_cause_status_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0;
  logic [7:0] causePulse = '0;
  logic [3:0] statPulse = '0;
  logic [2:0] phaseLines = '0;
  logic       rdStatus = 1'b0;
  logic       rdIntr = 1'b0;
  logic       intEnable = 1'b0;
  logic [7:0] rdData;
  logic       intOut;

  int testsRun = 0;
  int testsFailed = 0;

  // behavioural reference state
  int mCause = 0;
  int mStat = 0;
  int mPend = 0;

  always #2.5 clk = ~clk;

  cause_status_regs i_cause_status_regs (
    .clk        (clk),
    .rstN       (rstN),
    .swReset    (swReset),
    .causePulse (causePulse),
    .statPulse  (statPulse),
    .phaseLines (phaseLines),
    .rdStatus   (rdStatus),
    .rdIntr     (rdIntr),
    .intEnable  (intEnable),
    .rdData     (rdData),
    .intOut     (intOut)
  );

  task automatic check(input string tag, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // Drive one cycle of inputs, compare outputs, then advance the model.
  task automatic step(input int cp, input int sp, input int ph, input bit rs,
                      input bit ri, input bit sw, input bit en, input string tag);
    int expData;
    causePulse = cp[7:0];
    statPulse  = sp[3:0];
    phaseLines = ph[2:0];
    rdStatus   = rs;
    rdIntr     = ri;
    swReset    = sw;
    intEnable  = en;
    #1;
    if (ri)      expData = mCause;
    else if (rs) expData = (mPend << 7) | (mStat << 3) | ph;
    else         expData = 0;
    check({tag, " rdData"}, int'(rdData), expData);
    check({tag, " intOut"}, int'(intOut), (mPend != 0 && en) ? 1 : 0);
    @(posedge clk);
    if (!rstN) begin
      mCause = 0; mStat = 0; mPend = 0;
    end else if (sw) begin
      mCause = 0; mStat = 0; mPend = 0;
    end else if (ri) begin
      mCause = cp; mStat = sp; mPend = (cp != 0) ? 1 : 0;
    end else begin
      mCause = mCause | cp; mStat = mStat | sp;
      if (cp != 0) mPend = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int legal[6] = '{0, 1, 2, 3, 6, 7};
    @(negedge clk);
    // R1: reset state, pulses ignored while reset asserted
    step(8'hff, 4'hf, 3, 1, 0, 0, 1, "R1 in reset status");
    step(0, 0, 0, 0, 1, 0, 1, "R1 in reset intr");
    rstN = 1'b1;
    step(0, 0, 2, 1, 0, 0, 1, "R1 after reset status");
    step(0, 0, 2, 0, 1, 0, 1, "R1 after reset intr");

    // R2 R5: causes latch, pending sets with interrupts disabled
    step(8'h05, 0, 0, 0, 0, 0, 0, "R2 pulse");
    step(0, 0, 1, 1, 0, 0, 0, "R5 pending masked");
    step(0, 0, 1, 0, 0, 0, 1, "R6 enable");
    step(0, 0, 7, 1, 0, 0, 1, "R8 status read keeps");
    step(8'h40, 0, 7, 0, 0, 0, 1, "R2 accumulate");
    step(0, 0, 6, 0, 1, 0, 1, "R7 intr read");
    step(0, 0, 6, 1, 0, 0, 1, "R7 cleared status");
    step(0, 0, 6, 0, 1, 0, 1, "R7 cleared intr");

    // R3: each status bit
    for (int b = 0; b < 4; b++) begin
      step(0, 1 << b, 0, 0, 0, 0, 1, "R3 pulse");
      step(0, 0, 3, 1, 0, 0, 1, "R3 status");
      step(0, 0, 3, 1, 0, 0, 1, "R5 no pending from status");
      step(0, 0, 3, 0, 1, 0, 1, "R3 clear");
    end

    // R4: phase sweep over legal codes
    foreach (legal[k]) step(0, 0, legal[k], 1, 0, 0, 0, "R4 phase");

    // R9: event in the clearing cycle is kept
    step(8'h10, 4'h2, 0, 0, 0, 0, 1, "R9 setup");
    step(8'h80, 4'h8, 0, 0, 1, 0, 1, "R9 read with event");
    step(0, 0, 1, 1, 0, 0, 1, "R9 status after");
    step(0, 0, 1, 0, 1, 0, 1, "R9 next read");

    // R10: software reset discards everything
    step(8'h22, 4'h5, 0, 0, 0, 0, 1, "R10 setup");
    step(8'h01, 4'h1, 0, 0, 0, 1, 1, "R10 swreset");
    step(0, 0, 0, 1, 0, 0, 1, "R10 status after");
    step(0, 0, 0, 0, 1, 0, 1, "R10 intr after");

    // R11: idle and both strobes
    step(8'h08, 0, 2, 0, 0, 0, 1, "R11 idle");
    step(0, 0, 2, 1, 1, 0, 1, "R11 both strobes");

    // mixed traffic
    for (int n = 0; n < 150; n++) begin
      int cp = ($urandom % 4 == 0) ? int'($urandom % 256) : 0;
      int sp = ($urandom % 5 == 0) ? int'($urandom % 16) : 0;
      int rr = int'($urandom % 6);
      step(cp, sp, legal[$urandom % 6], rr == 1 || rr == 3, rr == 2 || rr == 3,
           ($urandom % 40) == 0, ($urandom % 2) == 1, "R2 R3 R7 mixed");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule